// File: doc/BRIEF.md
# Synchronism Check Permissive Logic

This block decides whether two energised systems on either side of a breaker are close enough in voltage, frequency and phase to allow the breaker to close. Upstream logic has already judged the voltage, frequency and angle differences and delivers one pass flag for each. The block also receives the digitised voltage magnitude and frequency of the reference side and of the other side. Both sides are held against shared voltage and frequency windows.

The permissive condition requires the function to be enabled, both blocking inputs to be inactive, all three difference flags to pass and all eight window comparisons to pass. A pickup timer then counts sample strobes while the condition holds. The output asserts once the programmed number of strobes is reached, and it drops on the first clock edge at which the condition fails. A registered status vector shows which window comparisons failed.

Top module: `sync_permit`

## Requirements
- R1: `sync_ok` is 0 after any clock edge at which `dv_ok`, `df_ok` or `da_ok` is 0.
- R2: `sync_ok` is 0 after any clock edge at which `en` is 0, `blk_sync` is 1 or `blk_all` is 1.
- R3: Voltage limits are strict. Each side uses the same limits. A side fails when its value is greater than `v_hi` (over) or less than `v_lo` (under). Any one failure forces `sync_ok` to 0. The failures are registered into `win_fail` at these bits: bit 0 is reference over, bit 1 is reference under, bit 2 is other-side over and bit 3 is other-side under.
- R4: Frequency limits are strict in the same way, using `f_hi` and `f_lo`. Bit 4 of `win_fail` is reference over, bit 5 is reference under, bit 6 is other-side over and bit 7 is other-side under. Any one failure forces `sync_ok` to 0.
- R5: While the condition holds without a break, `sync_ok` becomes 1 on the clock edge that samples the `dly`-th `smp_vld` strobe. When `dly` is 0, it becomes 1 on the first edge at which the condition holds.
- R6: When the condition fails at an edge, `sync_ok` is 0 after that same edge and the strobe count restarts from zero.
- R7: Once `dly` strobes have been counted, the count saturates. `sync_ok` stays 1 however many further strobes arrive, including when `dly` is the largest value its width allows.
- R8: The synchronous active-high `rst` clears `sync_ok`, `win_fail` and the strobe count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; advances the pickup count |
| en | input | 1 | Function enable |
| blk_sync | input | 1 | Block for this function only |
| blk_all | input | 1 | General synchro-check block |
| dv_ok | input | 1 | Voltage-difference pass flag |
| df_ok | input | 1 | Frequency-difference pass flag |
| da_ok | input | 1 | Angle-difference pass flag |
| v_ref | input | VW | Reference-side voltage magnitude |
| v_oth | input | VW | Other-side voltage magnitude |
| f_ref | input | FW | Reference-side frequency |
| f_oth | input | FW | Other-side frequency |
| v_hi | input | VW | Overvoltage limit |
| v_lo | input | VW | Undervoltage limit |
| f_hi | input | FW | Over-frequency limit |
| f_lo | input | FW | Under-frequency limit |
| dly | input | TW | Pickup delay, in strobes |
| sync_ok | output | 1 | Registered synchronism permissive |
| win_fail | output | 8 | Registered per-comparison failure flags |

## Verification
The pickup count can reach its target on the same edge at which the condition fails. In that case the reset of the timer must win. The bench provokes this in the dropout sequence: after the count has reached `dly`, it clears one difference flag on a strobe cycle and expects `sync_ok` to be 0. It then expects the full `dly` strobes to be counted again before `sync_ok` returns. A second coincidence is a window failure and the output drop happening on one edge. The window sweeps judge this by checking the failure bit and `sync_ok` = 0 together, after the same edge.

// File: rtl/sync_permit_pkg.sv
package sync_permit_pkg;
  localparam int NUM_SIDES = 2;
  localparam int WF_BITS   = 4 * NUM_SIDES;
  localparam int WF_VOLT   = 0;
  localparam int WF_FREQ   = 2 * NUM_SIDES;

  typedef struct packed {
    logic under;
    logic over;
  } win_res_t;
endpackage

// File: rtl/sp_window.sv
module sp_window
  import sync_permit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output win_res_t     res
);
  always_comb begin
    res.over  = (val > hi);
    res.under = (val < lo);
  end
endmodule

// File: rtl/sp_gate.sv
module sp_gate #(
  parameter int NF = 8
) (
  input  logic          en,
  input  logic          blk_sync,
  input  logic          blk_all,
  input  logic          dv_ok,
  input  logic          df_ok,
  input  logic          da_ok,
  input  logic [NF-1:0] fails,
  output logic          cond
);
  logic diffs_good;
  logic allowed;

  always_comb begin
    diffs_good = dv_ok & df_ok & da_ok;
    allowed    = en & ~blk_sync & ~blk_all;
    cond       = allowed & diffs_good & ~(|fails);
  end
endmodule

// File: rtl/sp_pickup.sv
module sp_pickup #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond,
  input  logic          smp_vld,
  input  logic [TW-1:0] dly,
  output logic          ok
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] cnt_nxt;

  always_comb begin
    if (!cond)
      cnt_nxt = '0;
    else if (smp_vld && (cnt < dly))
      cnt_nxt = cnt + 1'b1;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      ok  <= cond && (cnt_nxt >= dly);
    end
  end
endmodule

// File: rtl/sync_permit.sv
module sync_permit
  import sync_permit_pkg::*;
#(
  parameter int VW = 16,
  parameter int FW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic          en,
  input  logic          blk_sync,
  input  logic          blk_all,
  input  logic          dv_ok,
  input  logic          df_ok,
  input  logic          da_ok,
  input  logic [VW-1:0] v_ref,
  input  logic [VW-1:0] v_oth,
  input  logic [FW-1:0] f_ref,
  input  logic [FW-1:0] f_oth,
  input  logic [VW-1:0] v_hi,
  input  logic [VW-1:0] v_lo,
  input  logic [FW-1:0] f_hi,
  input  logic [FW-1:0] f_lo,
  input  logic [TW-1:0] dly,
  output logic          sync_ok,
  output logic [7:0]    win_fail
);
  logic [VW-1:0]        v_side [NUM_SIDES];
  logic [FW-1:0]        f_side [NUM_SIDES];
  logic [WF_BITS-1:0]   fail_now;
  logic                 cond;

  assign v_side[0] = v_ref;
  assign v_side[1] = v_oth;
  assign f_side[0] = f_ref;
  assign f_side[1] = f_oth;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    win_res_t vr;
    win_res_t fr;

    sp_window #(.W(VW)) u_vwin (
      .val(v_side[s]), .hi(v_hi), .lo(v_lo), .res(vr)
    );
    sp_window #(.W(FW)) u_fwin (
      .val(f_side[s]), .hi(f_hi), .lo(f_lo), .res(fr)
    );

    assign fail_now[WF_VOLT + 2*s]     = vr.over;
    assign fail_now[WF_VOLT + 2*s + 1] = vr.under;
    assign fail_now[WF_FREQ + 2*s]     = fr.over;
    assign fail_now[WF_FREQ + 2*s + 1] = fr.under;
  end

  sp_gate #(.NF(WF_BITS)) u_gate (
    .en(en), .blk_sync(blk_sync), .blk_all(blk_all),
    .dv_ok(dv_ok), .df_ok(df_ok), .da_ok(da_ok),
    .fails(fail_now), .cond(cond)
  );

  sp_pickup #(.TW(TW)) u_pick (
    .clk(clk), .rst(rst), .cond(cond), .smp_vld(smp_vld),
    .dly(dly), .ok(sync_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) win_fail <= '0;
    else     win_fail <= fail_now;
  end
endmodule

// File: rtl/sync_permit_chk.sv
module sync_permit_chk #(
  parameter int VW = 16,
  parameter int FW = 16,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld,
  input logic          en,
  input logic          blk_sync,
  input logic          blk_all,
  input logic          dv_ok,
  input logic          df_ok,
  input logic          da_ok,
  input logic [VW-1:0] v_ref,
  input logic [VW-1:0] v_oth,
  input logic [FW-1:0] f_ref,
  input logic [FW-1:0] f_oth,
  input logic [VW-1:0] v_hi,
  input logic [VW-1:0] v_lo,
  input logic [FW-1:0] f_hi,
  input logic [FW-1:0] f_lo,
  input logic [TW-1:0] dly,
  input logic          sync_ok,
  input logic [7:0]    win_fail
);
  AST_DIFF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !(dv_ok && df_ok && da_ok) |=> !sync_ok); // R1
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en || blk_sync || blk_all) |=> !sync_ok); // R2
  AST_VREF_OVER: assert property (@(posedge clk) disable iff (rst)
    (v_ref > v_hi) |=> (win_fail[0] && !sync_ok)); // R3
  AST_VOTH_UNDER: assert property (@(posedge clk) disable iff (rst)
    (v_oth < v_lo) |=> (win_fail[3] && !sync_ok)); // R3
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    sync_ok |-> (win_fail == 8'h00)); // R3
  AST_FREF_UNDER: assert property (@(posedge clk) disable iff (rst)
    (f_ref < f_lo) |=> (win_fail[5] && !sync_ok)); // R4
  AST_FOTH_OVER: assert property (@(posedge clk) disable iff (rst)
    (f_oth > f_hi) |=> (win_fail[6] && !sync_ok)); // R4
  AST_NO_RISE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!sync_ok && !smp_vld && (dly != '0) && $stable(dly)) |=> !sync_ok); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sync_ok && (win_fail == 8'h00))); // R8
endmodule

bind sync_permit sync_permit_chk #(.VW(VW), .FW(FW), .TW(TW)) u_chk (.*);

// File: tb/tb_sync_permit.sv
module tb_sync_permit;
  localparam int VW = 4;
  localparam int FW = 4;
  localparam int TW = 4;
  localparam logic [VW-1:0] VHI = 4'd10;
  localparam logic [VW-1:0] VLO = 4'd5;
  localparam logic [FW-1:0] FHI = 4'd11;
  localparam logic [FW-1:0] FLO = 4'd4;

  logic clk = 1'b0;
  logic rst, smp_vld, en, blk_sync, blk_all, dv_ok, df_ok, da_ok;
  logic [VW-1:0] v_ref, v_oth, v_hi, v_lo;
  logic [FW-1:0] f_ref, f_oth, f_hi, f_lo;
  logic [TW-1:0] dly;
  logic          sync_ok;
  logic [7:0]    win_fail;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sync_permit #(.VW(VW), .FW(FW), .TW(TW)) dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .en(en), .blk_sync(blk_sync),
    .blk_all(blk_all), .dv_ok(dv_ok), .df_ok(df_ok), .da_ok(da_ok),
    .v_ref(v_ref), .v_oth(v_oth), .f_ref(f_ref), .f_oth(f_oth),
    .v_hi(v_hi), .v_lo(v_lo), .f_hi(f_hi), .f_lo(f_lo), .dly(dly),
    .sync_ok(sync_ok), .win_fail(win_fail)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic set_good();
    en = 1; blk_sync = 0; blk_all = 0; dv_ok = 1; df_ok = 1; da_ok = 1;
    v_ref = 4'd8; v_oth = 4'd8; f_ref = 4'd8; f_oth = 4'd8;
    v_hi = VHI; v_lo = VLO; f_hi = FHI; f_lo = FLO;
    smp_vld = 0; dly = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_good();
    v_ref = 4'd15;
    rst = 1;
    step(); step();
    chk("R8 reset sync_ok", {7'd0, sync_ok}, 8'd0);
    chk("R8 reset win_fail", win_fail, 8'd0);
    rst = 0;

    // R3 / R4 window sweeps, each side alone
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        logic ov, un;
        logic [7:0] ewf;
        set_good();
        case (s)
          0: v_ref = v[3:0];
          1: v_oth = v[3:0];
          2: f_ref = v[3:0];
          default: f_oth = v[3:0];
        endcase
        if (s < 2) begin ov = (v > int'(VHI)); un = (v < int'(VLO)); end
        else       begin ov = (v > int'(FHI)); un = (v < int'(FLO)); end
        ewf = '0;
        ewf[2*s]     = ov;
        ewf[2*s + 1] = un;
        step();
        chk(s < 2 ? "R3 win_fail" : "R4 win_fail", win_fail, ewf);
        chk(s < 2 ? "R3 sync_ok" : "R4 sync_ok", {7'd0, sync_ok}, {7'd0, ~(ov | un)});
      end
    end

    // R1 / R2 gating sweep over all 64 combinations
    for (int c = 0; c < 64; c++) begin
      set_good();
      en = c[0]; blk_sync = c[1]; blk_all = c[2];
      dv_ok = c[3]; df_ok = c[4]; da_ok = c[5];
      step();
      chk((c[0] && !c[1] && !c[2]) ? "R1 gating" : "R2 gating",
          {7'd0, sync_ok},
          {7'd0, c[0] & ~c[1] & ~c[2] & c[3] & c[4] & c[5]});
    end

    // R5 pickup over delays and strobe spacing
    for (int d = 0; d < 6; d++) begin
      for (int p = 1; p <= 3; p += 2) begin
        int cnt;
        set_good(); en = 0; step();
        set_good(); dly = d[TW-1:0];
        cnt = 0;
        for (int k = 1; k <= 20; k++) begin
          smp_vld = (k % p == 0);
          if (smp_vld) cnt++;
          step();
          chk("R5 pickup", {7'd0, sync_ok}, {7'd0, cnt >= d});
        end
      end
    end

    // R6 dropout with coincident strobe, then full recount
    set_good(); en = 0; step();
    set_good(); dly = 4'd3; smp_vld = 1;
    step(); step(); step();
    chk("R6 reached before drop", {7'd0, sync_ok}, 8'd1);
    dv_ok = 0; step();
    chk("R6 drop immediate", {7'd0, sync_ok}, 8'd0);
    dv_ok = 1; step(); step();
    chk("R6 recount not done", {7'd0, sync_ok}, 8'd0);
    step();
    chk("R6 recount done", {7'd0, sync_ok}, 8'd1);

    // R7 saturation at max delay
    set_good(); en = 0; step();
    set_good(); dly = 4'd15; smp_vld = 1;
    for (int k = 1; k <= 40; k++) begin
      step();
      chk("R7 saturate", {7'd0, sync_ok}, {7'd0, k >= 15});
    end

    // R8 reset mid-run while permissive is up
    v_ref = 4'd15; rst = 1; step();
    chk("R8 mid reset sync_ok", {7'd0, sync_ok}, 8'd0);
    chk("R8 mid reset win_fail", win_fail, 8'd0);
    rst = 0; set_good(); step();
    chk("R8 after reset dly0", {7'd0, sync_ok}, 8'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule